// File: doc/BRIEF.md
# SHA-256 Message Schedule Generator

This block supplies the compression engine of a SHA-256 datapath with the 64 round words of one 512-bit padded block, one 32-bit word per round. The words of the first 16 rounds are the block's own words. Every later word is computed on demand from four earlier words, using the two small sigma mixing functions and 32-bit wrap-around addition.

The block never holds a 64-entry table. It keeps a sliding window of 16 words. The oldest entry of that window is the word for the current round. Each advance drops that entry and appends the word needed 16 rounds later. A load strobe captures a new block and starts again at round 0. Each advance moves to the next round. After round 63 the generator goes idle until the next load.

Top module: `msg_sched_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid_o` is 0, `round_o` is 0 and `word_o` is 0.
- R2: In the cycle after `load_i` is sampled high, `valid_o` is 1, `round_o` is 0 and `word_o` equals bits [511:480] of the loaded block.
- R3: For rounds t = 0 to 15, `word_o` equals block bits [511-32t : 480-32t]. The first word is the most significant one.
- R4: For rounds t = 16 to 63, `word_o` equals s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] modulo 2^32. Here s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R5: An advance sampled while valid, at a round below 63 and without a load, raises `round_o` by one. The next word appears in the following cycle.
- R6: While valid with neither `advance_i` nor `load_i`, `word_o`, `round_o` and `valid_o` hold their values.
- R7: An advance sampled at round 63 ends the block. In the next cycle `valid_o` is 0 and `round_o` is 0.
- R8: While not valid, `advance_i` has no effect: `word_o` and `round_o` stay unchanged and `valid_o` stays 0.
- R9: A load sampled in mid-block, even together with an advance, restarts at round 0 with the new block's first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture `block_i` and restart at round 0 |
| block_i | input | 512 | Padded message block, word 0 in bits [511:480] |
| advance_i | input | 1 | Step to the next round |
| word_o | output | 32 | Round word W for `round_o` |
| round_o | output | 6 | Current round index 0..63 |
| valid_o | output | 1 | A block is in progress and `word_o` is meaningful |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A load sampled at one edge shows round 0 and W0 after that edge. An advance shows the next index and word after its edge. The final advance shows the idle state after its edge. The bench drives inputs just after a falling edge and samples at the next falling edge, so each comparison falls in the cycle that follows the single rising edge in between. The bench computes all 64 expected words of each block arithmetically. It sweeps every round of several blocks, with idle gaps, idle advances and mid-block reloads.

// File: rtl/sha_sched_pkg.sv
// Shared types and mixing functions for the message schedule generator.
// Assumes 32-bit words, as fixed by the hash definition.
package sha_sched_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Rotate right by a constant amount
    function automatic word_t rotr(input word_t x, input int unsigned n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    // Small sigma applied to the word 15 rounds back
    function automatic word_t mix_lo(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    // Small sigma applied to the word 2 rounds back
    function automatic word_t mix_hi(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction
endpackage

// File: rtl/sched_expand.sv
// Combinational expansion: forms the word 16 rounds ahead of the
// oldest window entry. Assumes the caller presents the window taps
// at distances 0, 1, 9 and 14 from the oldest entry.
module sched_expand
    import sha_sched_pkg::*;
(
    input  word_t tap_old_i,   // W[t]
    input  word_t tap_p1_i,    // W[t+1]
    input  word_t tap_p9_i,    // W[t+9]
    input  word_t tap_p14_i,   // W[t+14]
    output word_t next_o       // W[t+16]
);
    // Sum of the four terms with 32-bit wrap-around
    always_comb begin
        next_o = mix_hi(tap_p14_i) + tap_p9_i + mix_lo(tap_p1_i) + tap_old_i;
    end
endmodule

// File: rtl/sched_window.sv
// Sliding window of DEPTH words. Entry 0 is the oldest (current round).
// A load fills it from a flat block with the most significant word in
// entry 0. A shift drops entry 0 and appends new_i at the top.
// Assumes load and shift are never both set (the top gives load priority).
module sched_window #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      shift_i,
    input  logic [W*DEPTH-1:0]        block_i,
    input  logic [W-1:0]              new_i,
    output logic [DEPTH-1:0][W-1:0]   win_o
);
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            logic [W-1:0] fill;
            // Value shifted into entry i
            if (i == DEPTH - 1) begin : g_top
                assign fill = new_i;
            end else begin : g_mid
                assign fill = win_o[i+1];
            end
            // Entry register: reset, load or shift
            always_ff @(posedge clk) begin
                if (!rst_n)       win_o[i] <= '0;
                else if (load_i)  win_o[i] <= block_i[(DEPTH-1-i)*W +: W];
                else if (shift_i) win_o[i] <= fill;
            end
        end
    endgenerate
endmodule

// File: rtl/sched_round_ctr.sv
// Round index and block-active flag. Assumes step_i is only set while
// active_o is 1 and load_i is 0 (the top gates it).
module sched_round_ctr #(
    parameter int ROUNDS = 64,
    localparam int RW    = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    output logic [RW-1:0] round_o,
    output logic          active_o
);
    localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

    // Index and active flag: restart on load, stop after the last round
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round_o  <= '0;
            active_o <= 1'b0;
        end else if (load_i) begin
            round_o  <= '0;
            active_o <= 1'b1;
        end else if (step_i) begin
            if (round_o == LAST) begin
                round_o  <= '0;
                active_o <= 1'b0;
            end else begin
                round_o  <= round_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/msg_sched_gen.sv
// Top: SHA-256 message schedule generator. Emits W0..W63 of one block,
// one word per advance, from a 16-word sliding window. Assumes the
// block is already padded; load wins over a simultaneous advance.
module msg_sched_gen
    import sha_sched_pkg::*;
#(
    parameter int ROUNDS = 64,
    parameter int WIN    = 16,
    localparam int RW    = $clog2(ROUNDS),
    localparam int BLK_W = WORD_W * WIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BLK_W-1:0] block_i,
    input  logic             advance_i,
    output logic [WORD_W-1:0] word_o,
    output logic [RW-1:0]    round_o,
    output logic             valid_o
);
    logic [WIN-1:0][WORD_W-1:0] win;
    word_t                      next_w;
    logic                       step;

    // Advance only counts during a block and when no load is pending
    assign step = advance_i & valid_o & ~load_i;

    sched_window #(.W(WORD_W), .DEPTH(WIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .shift_i (step),
        .block_i (block_i),
        .new_i   (next_w),
        .win_o   (win)
    );

    sched_expand u_exp (
        .tap_old_i (win[0]),
        .tap_p1_i  (win[1]),
        .tap_p9_i  (win[9]),
        .tap_p14_i (win[14]),
        .next_o    (next_w)
    );

    sched_round_ctr #(.ROUNDS(ROUNDS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .step_i   (step),
        .round_o  (round_o),
        .active_o (valid_o)
    );

    assign word_o = win[0];
endmodule

// File: rtl/msg_sched_gen_chk.sv
// Checker for msg_sched_gen, port-level temporal properties only.
module msg_sched_gen_chk #(
    parameter int ROUNDS = 64,
    parameter int RW     = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_i,
    input logic [511:0]  block_i,
    input logic          advance_i,
    input logic [31:0]   word_o,
    input logic [RW-1:0] round_o,
    input logic          valid_o
);
    localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> valid_o && round_o == '0 && word_o == $past(block_i[511:480]));

    assert_reload_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && advance_i && valid_o |=> round_o == '0 && valid_o);

    assert_step_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && advance_i && !load_i && round_o != LAST
        |=> valid_o && round_o == $past(round_o) + 1'b1);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !advance_i && !load_i
        |=> valid_o && $stable(word_o) && $stable(round_o));

    assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && advance_i && !load_i && round_o == LAST
        |=> !valid_o && round_o == '0);

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && !load_i |=> !valid_o && $stable(word_o) && $stable(round_o));
endmodule

bind msg_sched_gen msg_sched_gen_chk #(.ROUNDS(ROUNDS), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .block_i   (block_i),
    .advance_i (advance_i),
    .word_o    (word_o),
    .round_o   (round_o),
    .valid_o   (valid_o)
);

// File: tb/sim_msg_sched_gen.sv
module sim_msg_sched_gen;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [511:0] block_i = '0;
    logic         advance_i = 1'b0;
    logic [31:0]  word_o;
    logic [5:0]   round_o;
    logic         valid_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [31:0] exp_w [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_sched_gen u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .block_i(block_i),
        .advance_i(advance_i), .word_o(word_o), .round_o(round_o), .valid_o(valid_o)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        logic [63:0] d;
        d = {x, x} >> n;
        return d[31:0];
    endfunction

    // Expected schedule computed from the recurrence
    task automatic build_expected(input logic [511:0] b);
        for (int t = 0; t < 64; t++) begin
            if (t < 16) exp_w[t] = b[511 - 32*t -: 32];
            else exp_w[t] = (rr(exp_w[t-2], 17) ^ rr(exp_w[t-2], 19) ^ (exp_w[t-2] >> 10))
                          + exp_w[t-7]
                          + (rr(exp_w[t-15], 7) ^ rr(exp_w[t-15], 18) ^ (exp_w[t-15] >> 3))
                          + exp_w[t-16];
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: inputs were set after a falling edge, sample at the next one
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_block(input logic [511:0] b);
        build_expected(b);
        block_i = b; load_i = 1'b1;
        tick();
        load_i = 1'b0; block_i = ~b;
        check("R2 valid", 32'(valid_o), 32'd1);
        check("R2 round", 32'(round_o), 32'd0);
        check("R2 word", word_o, b[511:480]);
    endtask

    // Walk all rounds; gap inserts idle cycles to check R6
    task automatic run_block(input int gap);
        for (int t = 0; t < 64; t++) begin
            check(t < 16 ? "R3 word" : "R4 word", word_o, exp_w[t]);
            check("R5 round", 32'(round_o), 32'(t));
            if (gap > 0 && (t % 7) == 3) begin
                for (int g = 0; g < gap; g++) tick();
                check("R6 word hold", word_o, exp_w[t]);
                check("R6 round hold", 32'(round_o), 32'(t));
                check("R6 valid hold", 32'(valid_o), 32'd1);
            end
            advance_i = 1'b1;
            tick();
            advance_i = 1'b0;
        end
        check("R7 valid", 32'(valid_o), 32'd0);
        check("R7 round", 32'(round_o), 32'd0);
    endtask

    logic [31:0] held;
    logic [511:0] blk;

    initial begin
        tick(); tick();
        check("R1 valid", 32'(valid_o), 32'd0);
        check("R1 round", 32'(round_o), 32'd0);
        check("R1 word", word_o, 32'd0);
        rst_n = 1'b1;
        tick();
        check("R1 valid after", 32'(valid_o), 32'd0);
        check("R1 word after", word_o, 32'd0);

        // R8: advance before any block
        advance_i = 1'b1; tick(); tick(); advance_i = 1'b0;
        check("R8 valid", 32'(valid_o), 32'd0);
        check("R8 word", word_o, 32'd0);

        load_block({32'h61626380, 416'h0, 64'd24});
        run_block(0);
        check("R7 abc last word", exp_w[63], 32'h12b1edeb);

        // R8 after a finished block
        held = word_o;
        advance_i = 1'b1; tick(); tick(); advance_i = 1'b0;
        check("R8 word stable", word_o, held);
        check("R8 round", 32'(round_o), 32'd0);
        check("R8 valid", 32'(valid_o), 32'd0);

        load_block({512{1'b1}});
        run_block(2);
        load_block('0);
        run_block(1);
        for (int k = 0; k < 16; k++) blk[32*k +: 32] = 32'h9e3779b9 * (k + 1) ^ (32'h1234567 << k);
        load_block(blk);
        run_block(0);

        // R9: reload mid-block together with an advance
        load_block(~blk);
        for (int t = 0; t < 20; t++) begin advance_i = 1'b1; tick(); end
        check("R9 pre round", 32'(round_o), 32'd20);
        load_block(blk ^ {16{32'h5a5aa5a5}});
        advance_i = 1'b0;
        check("R9 restart round", 32'(round_o), 32'd0);
        for (int t = 0; t < 5; t++) begin advance_i = 1'b1; tick(); end
        advance_i = 1'b0;
        build_expected(blk ^ {16{32'h5a5aa5a5}});
        check("R9 word after restart", word_o, exp_w[5]);
        begin
            block_i = blk; load_i = 1'b1; advance_i = 1'b1;
            tick();
            load_i = 1'b0; advance_i = 1'b0;
            check("R9 load+advance round", 32'(round_o), 32'd0);
            check("R9 load+advance word", word_o, blk[511:480]);
        end
        build_expected(blk);
        run_block(0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule